// File: doc/BRIEF.md
# Oversampled Serial Receive Engine with Error Routing

This block recovers asynchronous serial characters from a single input line. An external rate generator supplies a one-cycle tick at sixteen times the bit rate. The line is resynchronised, and a falling edge arms a start-bit check at mid-bit. The engine then takes each data bit at its centre, least significant first, followed by an optional parity bit and one stop bit. A finished character is placed in a holding register, which the host empties with a read strobe.

Three sticky status flags report parity mismatch, a low stop bit, and a character lost because the holding register was still unread. Each character produces exactly one single-cycle pulse. A routing bit decides whether a character with any fault is signalled on the ordinary completion pulse or on a separate fault pulse. Two enables must both be high for the engine to run. Dropping either one abandons a character in flight and leaves the holding register and the flags as they were.

Top module: `serial_rx_engine`

## Requirements
- R1: After reset, rx_data is 0, buf_full, par_err, frm_err and ovr_err are 0, and neither done_irq nor err_irq is high.
- R2: While master_en or rx_en is low, no character is received: done_irq and err_irq stay low and rx_data and buf_full keep their values.
- R3: A low level on rx_line that has gone high again by the 8th oversampling tick after its falling edge is discarded and produces no pulse.
- R4: Data bits are taken at the bit centre (every 16 ticks), least significant first. With len7=1 seven bits are received and rx_data[7] reads 0; with len7=0 eight bits are received. rx_data changes only in the cycle in which done_irq or err_irq is high.
- R5: par_mode selects the parity bit following the data: 2'b00 or 2'b11 none, 2'b01 even, 2'b10 odd. A mismatch sets par_err and the data is still written to rx_data.
- R6: A stop bit sampled low sets frm_err and the data is still written to rx_data.
- R7: If buf_full is high and no read strobe is present when a character completes, ovr_err is set and rx_data keeps its previous value.
- R8: Each completed character gives one pulse of one cycle. If the character has a parity, framing or overrun fault and err_route=1, the pulse appears on err_irq. Otherwise it appears on done_irq. The two pulses are never high together.
- R9: Lowering rx_en during a character abandons it: no pulse follows, and rx_data, buf_full and the three flags are left unchanged.
- R10: rd_strobe clears buf_full. A rd_strobe in the same cycle as a completing character counts as a read made first: there is no overrun, the new data is stored and buf_full stays 1.
- R11: par_err, frm_err and ovr_err stay set across later characters until clr_err is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle tick at 16x the bit rate |
| master_en | input | 1 | Master enable |
| rx_en | input | 1 | Receive enable; low aborts a character |
| len7 | input | 1 | 1 = seven data bits, 0 = eight |
| par_mode | input | 2 | Parity selection (see R5) |
| err_route | input | 1 | 1 = faulty characters signalled on err_irq |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_strobe | input | 1 | Host read of rx_data, clears buf_full |
| clr_err | input | 1 | Clears the three fault flags |
| rx_data | output | 8 | Holding register |
| buf_full | output | 1 | Holding register contains an unread character |
| par_err | output | 1 | Sticky parity fault |
| frm_err | output | 1 | Sticky framing fault |
| ovr_err | output | 1 | Sticky overrun fault |
| done_irq | output | 1 | Completion pulse |
| err_irq | output | 1 | Fault pulse |

## Verification
A host read and the completion of a new character can fall in the same clock cycle. That cycle decides whether the character is stored or counted as an overrun. The bench first receives a calibration character that is aligned to the tick phase and measures the cycle in which the pulse appears. It then leaves the holding register full and sends a second character of the same format, driving rd_strobe exactly one cycle before the pulse it now expects. The result is judged correct when the pulse is on done_irq, ovr_err stays low, rx_data carries the new character and buf_full is still set.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [1:0] {
      PM_OFF  = 2'b00,
      PM_EVEN = 2'b01,
      PM_ODD  = 2'b10,
      PM_OFF2 = 2'b11
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   function automatic logic par_enabled(input logic [1:0] m);
      return (m == PM_EVEN) || (m == PM_ODD);
   endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic fall
);

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign level = chain[STAGES-1];
   assign fall  = prev & ~chain[STAGES-1];

endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int OS_RATE = 16,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tick,
   input  logic              line,
   input  logic              fall,
   input  logic              len7,
   input  logic [1:0]        par_mode,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              perr,
   output logic              ferr
);

   localparam int CNT_W = $clog2(OS_RATE);
   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] MID_TICK = CNT_W'(OS_RATE / 2 - 1);
   localparam logic [CNT_W-1:0] END_TICK = CNT_W'(OS_RATE - 1);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  last_idx;
   logic [DATA_W-1:0] sr;
   logic              acc;
   logic              perr_q;
   logic              at_end;
   logic              par_fault;

   assign last_idx  = len7 ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
   assign at_end    = tick && (cnt == END_TICK);
   assign par_fault = (acc ^ line) ^ (par_mode == PM_ODD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         idx    <= '0;
         sr     <= '0;
         acc    <= 1'b0;
         perr_q <= 1'b0;
      end else if (!active) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (fall) state <= ST_START;
            end
            ST_START: begin
               if (tick) begin
                  if (cnt == MID_TICK) begin
                     cnt    <= '0;
                     idx    <= '0;
                     acc    <= 1'b0;
                     perr_q <= 1'b0;
                     state  <= line ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (at_end) begin
                  cnt <= '0;
                  sr  <= {line, sr[DATA_W-1:1]};
                  acc <= acc ^ line;
                  idx <= idx + 1'b1;
                  if (idx == last_idx)
                     state <= par_enabled(par_mode) ? ST_PAR : ST_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PAR: begin
               if (at_end) begin
                  cnt    <= '0;
                  perr_q <= par_fault;
                  state  <= ST_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (at_end) begin
                  cnt   <= '0;
                  state <= ST_IDLE;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done = active && (state == ST_STOP) && at_end;
   assign data = len7 ? {1'b0, sr[DATA_W-1:1]} : sr;
   assign perr = perr_q;
   assign ferr = ~line;

endmodule

// File: rtl/srx_status.sv
module srx_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] data,
   input  logic              perr,
   input  logic              ferr,
   input  logic              err_route,
   input  logic              rd_strobe,
   input  logic              clr_err,
   output logic [DATA_W-1:0] rx_data,
   output logic              buf_full,
   output logic              par_err,
   output logic              frm_err,
   output logic              ovr_err,
   output logic              done_irq,
   output logic              err_irq
);

   logic still_full;
   logic lost;
   logic load;
   logic faulty;

   assign still_full = buf_full & ~rd_strobe;
   assign lost       = done & still_full;
   assign load       = done & ~still_full;
   assign faulty     = lost | (load & (perr | ferr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         buf_full <= 1'b0;
         par_err  <= 1'b0;
         frm_err  <= 1'b0;
         ovr_err  <= 1'b0;
         done_irq <= 1'b0;
         err_irq  <= 1'b0;
      end else begin
         if (load) begin
            rx_data  <= data;
            buf_full <= 1'b1;
         end else if (rd_strobe) begin
            buf_full <= 1'b0;
         end
         par_err  <= (par_err & ~clr_err) | (load & perr);
         frm_err  <= (frm_err & ~clr_err) | (load & ferr);
         ovr_err  <= (ovr_err & ~clr_err) | lost;
         done_irq <= done & ~(faulty & err_route);
         err_irq  <= done & faulty & err_route;
      end
   end

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine #(
   parameter int OS_RATE     = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              master_en,
   input  logic              rx_en,
   input  logic              len7,
   input  logic [1:0]        par_mode,
   input  logic              err_route,
   input  logic              rx_line,
   input  logic              rd_strobe,
   input  logic              clr_err,
   output logic [DATA_W-1:0] rx_data,
   output logic              buf_full,
   output logic              par_err,
   output logic              frm_err,
   output logic              ovr_err,
   output logic              done_irq,
   output logic              err_irq
);

   generate
      if (OS_RATE < 4 || (OS_RATE % 2) != 0) begin : g_bad_rate
         $error("OS_RATE must be even and at least 4");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              active;
   logic              line_s;
   logic              line_fall;
   logic              fr_done;
   logic [DATA_W-1:0] fr_data;
   logic              fr_perr;
   logic              fr_ferr;

   assign active = master_en & rx_en;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rx_line),
      .level (line_s),
      .fall  (line_fall)
   );

   srx_framer #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .tick     (os_tick),
      .line     (line_s),
      .fall     (line_fall),
      .len7     (len7),
      .par_mode (par_mode),
      .done     (fr_done),
      .data     (fr_data),
      .perr     (fr_perr),
      .ferr     (fr_ferr)
   );

   srx_status #(.DATA_W(DATA_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (fr_done),
      .data      (fr_data),
      .perr      (fr_perr),
      .ferr      (fr_ferr),
      .err_route (err_route),
      .rd_strobe (rd_strobe),
      .clr_err   (clr_err),
      .rx_data   (rx_data),
      .buf_full  (buf_full),
      .par_err   (par_err),
      .frm_err   (frm_err),
      .ovr_err   (ovr_err),
      .done_irq  (done_irq),
      .err_irq   (err_irq)
   );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_en,
   input logic              rx_en,
   input logic              rd_strobe,
   input logic              clr_err,
   input logic [DATA_W-1:0] rx_data,
   input logic              buf_full,
   input logic              par_err,
   input logic              frm_err,
   input logic              ovr_err,
   input logic              done_irq,
   input logic              err_irq
);

   AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_irq && err_irq)); // R8

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq); // R8

   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |=> !err_irq); // R8

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(master_en && rx_en)) |-> (!done_irq && !err_irq)); // R2

   AST_DATA_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> (done_irq || err_irq)); // R4

   AST_FULL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $past(buf_full && !rd_strobe) |-> $stable(rx_data)); // R7

   AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(par_err && !clr_err) |-> par_err); // R11

   AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frm_err && !clr_err) |-> frm_err); // R11

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ovr_err && !clr_err) |-> ovr_err); // R11

endmodule

bind serial_rx_engine srx_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .master_en (master_en),
   .rx_en     (rx_en),
   .rd_strobe (rd_strobe),
   .clr_err   (clr_err),
   .rx_data   (rx_data),
   .buf_full  (buf_full),
   .par_err   (par_err),
   .frm_err   (frm_err),
   .ovr_err   (ovr_err),
   .done_irq  (done_irq),
   .err_irq   (err_irq)
);

// File: tb/serial_rx_engine_tb.sv
module serial_rx_engine_tb;

   localparam int BIT_CLKS = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick;
   logic       master_en = 1'b0;
   logic       rx_en = 1'b0;
   logic       len7 = 1'b0;
   logic [1:0] par_mode = 2'b00;
   logic       err_route = 1'b0;
   logic       rx_line = 1'b1;
   logic       rd_strobe = 1'b0;
   logic       clr_err = 1'b0;
   logic [7:0] rx_data;
   logic       buf_full, par_err, frm_err, ovr_err, done_irq, err_irq;

   logic [1:0] tdiv = 2'd0;
   int checks = 0;
   int errors = 0;

   assign os_tick = (tdiv == 2'd3);

   always #10 clk = ~clk;

   initial forever begin
      @(posedge clk);
      tdiv <= tdiv + 2'd1;
   end

   serial_rx_engine u_dut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .master_en(master_en),
      .rx_en(rx_en), .len7(len7), .par_mode(par_mode), .err_route(err_route),
      .rx_line(rx_line), .rd_strobe(rd_strobe), .clr_err(clr_err),
      .rx_data(rx_data), .buf_full(buf_full), .par_err(par_err),
      .frm_err(frm_err), .ovr_err(ovr_err), .done_irq(done_irq), .err_irq(err_irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] masked(input logic [7:0] d, input bit l7);
      return l7 ? (d & 8'h7F) : d;
   endfunction

   function automatic logic good_par(input logic [7:0] d, input bit l7, input logic [1:0] pm);
      return (^masked(d, l7)) ^ (pm == 2'b10);
   endfunction

   function automatic bit has_par(input logic [1:0] pm);
      return (pm == 2'b01) || (pm == 2'b10);
   endfunction

   int nd, ne, off;

   task automatic send(input logic [7:0] d, input bit flip, input bit stopv,
                       input int rd_at, input int abort_at);
      int  nb, nbit, b;
      logic pb;
      nb   = len7 ? 7 : 8;
      nbit = 1 + nb + (has_par(par_mode) ? 1 : 0) + 1;
      pb   = good_par(d, len7, par_mode) ^ flip;
      nd = 0; ne = 0; off = -1;
      do @(negedge clk); while (tdiv != 2'd0);
      for (int i = 0; i < (nbit + 1) * BIT_CLKS; i++) begin
         if (i > 0) @(negedge clk);
         if (done_irq) begin nd++; off = i; end
         if (err_irq)  begin ne++; off = i; end
         b = i / BIT_CLKS;
         if (b == 0)                         rx_line = 1'b0;
         else if (b <= nb)                   rx_line = d[b-1];
         else if (b == nb + 1 && has_par(par_mode)) rx_line = pb;
         else if (b == nbit - 1)             rx_line = stopv;
         else                                rx_line = 1'b1;
         rd_strobe = (i == rd_at);
         if (i == abort_at) rx_en = 1'b0;
      end
      @(negedge clk);
      rd_strobe = 1'b0;
      rx_line   = 1'b1;
   endtask

   task automatic pulse_rd();
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr_err = 1'b1;
      @(negedge clk); clr_err = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int calib;
      logic [7:0] d;
      bit fl, sv, bad;
      void'($urandom(32'h5EED_1234));

      repeat (5) @(negedge clk);
      check("R1 rx_data", rx_data, 0);
      check("R1 flags", {buf_full, par_err, frm_err, ovr_err}, 0);
      check("R1 pulses", {done_irq, err_irq}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 after release", {rx_data, buf_full, par_err, frm_err, ovr_err, done_irq, err_irq}, 0);

      // R2: one enable low at a time
      rx_en = 1'b1; master_en = 1'b0;
      send(8'hA5, 0, 1, -1, -1);
      check("R2 master off pulses", nd + ne, 0);
      check("R2 master off buffer", {buf_full, rx_data}, 0);
      master_en = 1'b1; rx_en = 1'b0;
      send(8'hA5, 0, 1, -1, -1);
      check("R2 rx off pulses", nd + ne, 0);
      check("R2 rx off buffer", {buf_full, rx_data}, 0);
      rx_en = 1'b1;

      // R4: 8N1 calibration frame
      send(8'h3C, 0, 1, -1, -1);
      calib = off;
      check("R4 8bit done", {nd[7:0], ne[7:0]}, 16'h0100);
      check("R4 8bit data", rx_data, 8'h3C);
      check("R10 full after load", buf_full, 1);
      pulse_rd();
      check("R10 read clears", buf_full, 0);

      // R4: seven data bits
      len7 = 1'b1;
      send(8'hFF, 0, 1, -1, -1);
      check("R4 7bit data", rx_data, 8'h7F);
      pulse_rd();
      len7 = 1'b0;

      // R3: short glitch
      do @(negedge clk); while (tdiv != 2'd0);
      rx_line = 1'b0;
      repeat (20) @(negedge clk);
      rx_line = 1'b1;
      nd = 0; ne = 0;
      for (int i = 0; i < 800; i++) begin
         @(negedge clk);
         if (done_irq) nd++;
         if (err_irq)  ne++;
      end
      check("R3 glitch no pulse", nd + ne, 0);
      check("R3 glitch no load", {buf_full, rx_data}, {1'b0, 8'h7F});

      // R5 / R8: parity
      par_mode = 2'b01; err_route = 1'b1;
      send(8'h07, 0, 1, -1, -1);
      check("R5 even good", {nd[3:0], ne[3:0], 3'b0, par_err}, 12'h100);
      check("R5 even good data", rx_data, 8'h07);
      pulse_rd();
      par_mode = 2'b10;
      send(8'h81, 1, 1, -1, -1);
      check("R8 odd bad on err_irq", {nd[3:0], ne[3:0]}, 8'h01);
      check("R5 odd bad flag", par_err, 1);
      check("R5 odd bad data kept", rx_data, 8'h81);
      pulse_rd(); pulse_clr();
      check("R11 clear parity", par_err, 0);

      // R6 / R8 / R11: framing
      par_mode = 2'b00; err_route = 1'b0;
      send(8'h5A, 0, 0, -1, -1);
      check("R8 frame err on done_irq", {nd[3:0], ne[3:0]}, 8'h10);
      check("R6 frame flag", frm_err, 1);
      check("R6 frame data", rx_data, 8'h5A);
      pulse_rd();
      send(8'h66, 0, 1, -1, -1);
      check("R11 frm sticky", frm_err, 1);
      pulse_rd(); pulse_clr();
      check("R11 frm cleared", frm_err, 0);

      // R7 / R8: overrun
      send(8'h11, 0, 1, -1, -1);
      err_route = 1'b1;
      send(8'h22, 0, 1, -1, -1);
      check("R7 overrun flag", ovr_err, 1);
      check("R7 old data kept", rx_data, 8'h11);
      check("R8 overrun on err_irq", {nd[3:0], ne[3:0]}, 8'h01);
      err_route = 1'b0;
      send(8'h33, 0, 1, -1, -1);
      check("R8 overrun on done_irq", {nd[3:0], ne[3:0]}, 8'h10);
      check("R7 data still old", rx_data, 8'h11);
      pulse_rd(); pulse_clr();

      // R9: abort mid-frame (stop bit would be low)
      send(8'h99, 0, 0, -1, 4 * BIT_CLKS);
      check("R9 abort no pulse", nd + ne, 0);
      check("R9 abort state kept", {rx_data, buf_full, par_err, frm_err, ovr_err}, {8'h11, 4'b0000});
      rx_en = 1'b1;

      // R10: read in the completing cycle
      send(8'h44, 0, 1, -1, -1);
      send(8'h55, 0, 1, calib - 1, -1);
      check("R10 collision pulse", {nd[3:0], ne[3:0]}, 8'h10);
      check("R10 collision no overrun", ovr_err, 0);
      check("R10 collision data", rx_data, 8'h55);
      check("R10 collision full", buf_full, 1);
      pulse_rd();

      // random frames
      for (int k = 0; k < 24; k++) begin
         d         = 8'($urandom);
         len7      = 1'($urandom);
         par_mode  = 2'($urandom % 3);
         err_route = 1'($urandom);
         fl        = has_par(par_mode) && ($urandom % 4 == 0);
         sv        = ($urandom % 5) != 0;
         bad       = fl || !sv;
         send(d, fl, sv, -1, -1);
         check("R4 random data", rx_data, masked(d, len7));
         check("R5 random parity", par_err, fl);
         check("R6 random stop", frm_err, !sv);
         check("R8 random route", {nd[3:0], ne[3:0]},
               (bad && err_route) ? 8'h01 : 8'h10);
         pulse_rd(); pulse_clr();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule